// File: doc/BRIEF.md
# Chained Command and Interrupt Unit

This block is the host-side command and status logic of a token-passing network node. The host writes byte commands into a command register: transmit from a buffer page, enable reception into a page, disable the transmitter, disable the receiver, clear flags and software reset. The block keeps the status bits and an interrupt mask, and it drives a single interrupt line from the masked status. It hands the pending transmit and receive pages to the packet engine. The packet engine reports back through one-cycle strobes: transmit finished (with an acknowledge flag), receive finished, and token seen.

A configuration bit selects the mode. In legacy mode only one transmit and one receive command can be outstanding. In chaining mode each direction holds a queue of two. The masking also changes with the mode. In chaining mode the receive mask bit gates the chained receive-complete flag instead of the receiver-inhibited flag. The interrupt line has a guaranteed low gap between assertions.

Top module: `cmd_irq_unit`

## Requirements
- R1: After hardware reset, and after a software-reset command (opcode 7), status bits 7, 4 and 0 read 1 and bits 3..1 read 0. Bits 6 and 5 are undefined. The interrupt is low and the overflow flag is 0.
- R2: Status bit 4 (power-on flag) is set by hardware reset, by software reset, and in any cycle where node_id_zero_i is high. Only the clear-flags command (opcode 1) clears it.
- R3: The chaining mode is off after hardware reset. A write with wr_sel_i = 2 (configuration) loads the mode from wr_data_i bit 6.
- R4: In chaining mode, two transmit commands (opcode 4, page in bits 7..4) can be pending at once. They are served in write order: tx_page_o shows the oldest, and each tx_done_i retires one.
- R5: An accepted transmit command clears status bit 0 (transmitter available) and bit 1 (transmit acknowledged) in the next cycle. Bit 0 returns to 1 once the transmit queue is empty. tx_done_i sets bit 1 when tx_ack_i is high.
- R6: A transmit or receive command written while its queue is full (one entry in legacy mode, two in chaining mode) is dropped, and overflow_o is set and stays set until hardware reset.
- R7: In legacy mode the interrupt is (bit0 AND mask0) OR (bit7 AND mask7). In chaining mode mask bit 7 instead gates status bit 2 (chained receive complete). The interrupt follows one cycle after the status and mask change.
- R8: After the interrupt falls, it stays low for at least IRQ_GAP cycles (25 cycles, 200 ns at 125 MHz).
- R9: The disable-receiver command (opcode 3) sets status bit 7 (receiver inhibited) and drops the pending receive at the next token_i seen while rx_busy_i is low. A reception already in progress completes through rx_done_i first.
- R10: The disable-transmitter command (opcode 2) drops all pending transmits at the next token_i, so bit 0 reads 1 and tx_go_o falls.
- R11: A receive command (opcode 5) clears status bit 7 until its queue empties. In chaining mode, rx_done_i sets status bit 2, and the clear-flags command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Register select: 0 command, 1 mask, 2 configuration |
| wr_data_i | input | 8 | Write data |
| tx_done_i | input | 1 | Transmit finished strobe |
| tx_ack_i | input | 1 | Transmit was acknowledged (with tx_done_i) |
| rx_done_i | input | 1 | Receive finished strobe |
| rx_busy_i | input | 1 | A reception is in progress |
| token_i | input | 1 | Token arrival strobe |
| node_id_zero_i | input | 1 | Node identifier equals zero |
| status_o | output | 8 | Status register |
| mask_o | output | 8 | Interrupt mask register |
| chain_o | output | 1 | Chaining mode active |
| irq_o | output | 1 | Interrupt request |
| overflow_o | output | 1 | Sticky command drop flag |
| tx_go_o | output | 1 | A transmit is pending |
| tx_page_o | output | 4 | Page of oldest pending transmit |
| rx_go_o | output | 1 | A receive is pending |
| rx_page_o | output | 4 | Page of oldest pending receive |

## Verification
Every status, queue and flag result is registered on the edge that samples a write or strobe, so it is due one cycle after the stimulus. The interrupt passes through one more register and is due two cycles after the status-changing event. The bench drives on falling edges and holds each strobe for one cycle. It reads status right after that strobe and reads the interrupt one falling edge later. The interrupt gap is measured by counting falling-edge samples with the line low after the drop; 26 are due, the gap plus the re-arm cycle.

// File: rtl/cmd_irq_pkg.sv
package cmd_irq_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_CLR_FLAGS = 4'h1,
    OPC_DIS_TX    = 4'h2,
    OPC_DIS_RX    = 4'h3,
    OPC_TX_PAGE   = 4'h4,
    OPC_RX_PAGE   = 4'h5,
    OPC_SOFT_RST  = 4'h7
  } opcode_e;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;

  localparam int ST_TA  = 0;
  localparam int ST_TMA = 1;
  localparam int ST_TRI = 2;
  localparam int ST_POR = 4;
  localparam int ST_RI  = 7;
  localparam int CFG_CHAIN = 6;
endpackage

// File: rtl/cmd_slot_fifo.sv
module cmd_slot_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic [CW-1:0] limit_i,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          empty_o,
  output logic [W-1:0]  head_o
);
  logic [CW-1:0] count_q, count_n, widx;
  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_n [DEPTH];

  assign pop_ok_o  = pop_i && !flush_i && (count_q != '0);
  assign push_ok_o = push_i && !flush_i && (count_q < limit_i) &&
                     (count_q < CW'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign head_o    = slot_q[0];
  assign widx      = count_q - CW'(pop_ok_o);

  always_comb begin
    count_n = flush_i ? '0 : count_q + CW'(push_ok_o) - CW'(pop_ok_o);
    for (int i = 0; i < DEPTH; i++) begin
      slot_n[i] = slot_q[i];
      if (pop_ok_o && i < DEPTH - 1) slot_n[i] = slot_q[i+1];
      if (push_ok_o && widx == CW'(i)) slot_n[i] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      count_q <= count_n;
      if (push_ok_o || pop_ok_o)
        for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
    end
  end
endmodule

// File: rtl/irq_holdoff.sv
module irq_holdoff #(
  parameter int GAP = 25,
  localparam int GW = $clog2(GAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic irq_o
);
  logic          irq_q, irq_n;
  logic [GW-1:0] gap_q, gap_n;

  always_comb begin
    irq_n = irq_q;
    gap_n = gap_q;
    if (irq_q) begin
      if (!req_i) begin
        irq_n = 1'b0;
        gap_n = GW'(GAP);
      end
    end else if (gap_q != '0) begin
      gap_n = gap_q - 1'b1;
    end else begin
      irq_n = req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      gap_q <= '0;
    end else begin
      irq_q <= irq_n;
      gap_q <= gap_n;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmd_irq_unit.sv
module cmd_irq_unit
  import cmd_irq_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int QUEUE_DEPTH = 2,
  parameter int IRQ_GAP     = 25,
  localparam int PAGE_W     = CMD_W - OPC_W,
  localparam int LW         = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              tx_done_i,
  input  logic              tx_ack_i,
  input  logic              rx_done_i,
  input  logic              rx_busy_i,
  input  logic              token_i,
  input  logic              node_id_zero_i,
  output logic [7:0]        status_o,
  output logic [7:0]        mask_o,
  output logic              chain_o,
  output logic              irq_o,
  output logic              overflow_o,
  output logic              tx_go_o,
  output logic [PAGE_W-1:0] tx_page_o,
  output logic              rx_go_o,
  output logic [PAGE_W-1:0] rx_page_o
);
  logic             cmd_wr, mask_wr, cfg_wr;
  logic [OPC_W-1:0] opc;
  logic [PAGE_W-1:0] page;
  logic             soft_rst, clr_flags, tx_push, rx_push;
  logic             tx_flush, rx_flush;
  logic             tx_push_ok, tx_pop_ok, tx_empty;
  logic             rx_push_ok, rx_pop_ok, rx_empty;
  logic [LW-1:0]    limit;
  logic             irq_req;

  logic       por_q, por_n, tma_q, tma_n, tri_q, tri_n;
  logic       dtx_q, dtx_n, drx_q, drx_n;
  logic       chain_q, chain_n, ovf_q, ovf_n;
  logic [7:0] mask_q, mask_n;

  assign cmd_wr    = wr_en_i && (wr_sel_i == SEL_CMD);
  assign mask_wr   = wr_en_i && (wr_sel_i == SEL_MASK);
  assign cfg_wr    = wr_en_i && (wr_sel_i == SEL_CFG);
  assign opc       = wr_data_i[OPC_W-1:0];
  assign page      = wr_data_i[CMD_W-1:OPC_W];
  assign soft_rst  = cmd_wr && (opc == OPC_SOFT_RST);
  assign clr_flags = cmd_wr && (opc == OPC_CLR_FLAGS);
  assign tx_push   = cmd_wr && (opc == OPC_TX_PAGE);
  assign rx_push   = cmd_wr && (opc == OPC_RX_PAGE);
  assign tx_flush  = soft_rst || (token_i && dtx_q);
  assign rx_flush  = soft_rst || (token_i && drx_q && !rx_busy_i);
  assign limit     = chain_q ? LW'(QUEUE_DEPTH) : LW'(1);

  cmd_slot_fifo #(.DEPTH(QUEUE_DEPTH), .W(PAGE_W)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(page), .pop_i(tx_done_i),
    .flush_i(tx_flush), .limit_i(limit), .push_ok_o(tx_push_ok),
    .pop_ok_o(tx_pop_ok), .empty_o(tx_empty), .head_o(tx_page_o));

  cmd_slot_fifo #(.DEPTH(QUEUE_DEPTH), .W(PAGE_W)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(page), .pop_i(rx_done_i),
    .flush_i(rx_flush), .limit_i(limit), .push_ok_o(rx_push_ok),
    .pop_ok_o(rx_pop_ok), .empty_o(rx_empty), .head_o(rx_page_o));

  always_comb begin
    por_n   = por_q;
    tma_n   = tma_q;
    tri_n   = tri_q;
    dtx_n   = dtx_q;
    drx_n   = drx_q;
    chain_n = chain_q;
    mask_n  = mask_q;
    ovf_n   = ovf_q;

    if (soft_rst || node_id_zero_i) por_n = 1'b1;
    else if (clr_flags)             por_n = 1'b0;

    if (soft_rst)                    tma_n = 1'b0;
    else if (tx_push_ok)             tma_n = 1'b0;
    else if (tx_pop_ok && tx_ack_i)  tma_n = 1'b1;

    if (soft_rst)                    tri_n = 1'b0;
    else if (rx_pop_ok && chain_q)   tri_n = 1'b1;
    else if (clr_flags)              tri_n = 1'b0;

    if (soft_rst)                                 dtx_n = 1'b0;
    else if (cmd_wr && opc == OPC_DIS_TX)         dtx_n = 1'b1;
    else if (token_i)                             dtx_n = 1'b0;

    if (soft_rst)                                 drx_n = 1'b0;
    else if (cmd_wr && opc == OPC_DIS_RX)         drx_n = 1'b1;
    else if (token_i && !rx_busy_i)               drx_n = 1'b0;

    if (cfg_wr)  chain_n = wr_data_i[CFG_CHAIN];
    if (mask_wr) mask_n  = wr_data_i[7:0];

    if ((tx_push && !tx_push_ok && !tx_flush) ||
        (rx_push && !rx_push_ok && !rx_flush))
      ovf_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q   <= 1'b1;
      tma_q   <= 1'b0;
      tri_q   <= 1'b0;
      dtx_q   <= 1'b0;
      drx_q   <= 1'b0;
      chain_q <= 1'b0;
      mask_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      por_q   <= por_n;
      tma_q   <= tma_n;
      tri_q   <= tri_n;
      dtx_q   <= dtx_n;
      drx_q   <= drx_n;
      chain_q <= chain_n;
      mask_q  <= mask_n;
      ovf_q   <= ovf_n;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_TA]  = tx_empty;
    status_o[ST_TMA] = tma_q;
    status_o[ST_TRI] = tri_q;
    status_o[ST_POR] = por_q;
    status_o[ST_RI]  = rx_empty;
  end

  assign irq_req = (status_o[ST_TA] && mask_q[ST_TA]) ||
                   (mask_q[ST_RI] && (chain_q ? tri_q : rx_empty));

  irq_holdoff #(.GAP(IRQ_GAP)) u_irq (
    .clk_i, .rst_ni, .req_i(irq_req), .irq_o(irq_o));

  assign mask_o     = mask_q;
  assign chain_o    = chain_q;
  assign overflow_o = ovf_q;
  assign tx_go_o    = !tx_empty;
  assign rx_go_o    = !rx_empty;
endmodule

// File: rtl/cmd_irq_unit_chk.sv
module cmd_irq_unit_chk #(
  parameter int IRQ_GAP = 25,
  localparam int GW     = $clog2(IRQ_GAP + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       node_id_zero_i,
  input logic [7:0] status_o,
  input logic [7:0] mask_o,
  input logic       chain_o,
  input logic       irq_o,
  input logic       overflow_o,
  input logic       tx_acc
);
  logic          irq_d;
  logic [GW-1:0] low_cnt;
  logic          src;

  assign src = (status_o[0] && mask_o[0]) ||
               (mask_o[7] && (chain_o ? status_o[2] : status_o[7]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_d   <= 1'b0;
      low_cnt <= '0;
    end else begin
      irq_d <= irq_o;
      if (irq_d && !irq_o)  low_cnt <= GW'(IRQ_GAP - 1);
      else if (low_cnt != '0) low_cnt <= low_cnt - 1'b1;
    end
  end

  // R2
  por_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    node_id_zero_i |=> status_o[4]);

  // R3
  chain_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2) |=> (chain_o == $past(wr_data_i[6])));

  // R5
  tx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_acc |=> (!status_o[0] && !status_o[1]));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(src));

  // R8
  irq_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_cnt != '0) |-> !irq_o);
endmodule

bind cmd_irq_unit cmd_irq_unit_chk #(.IRQ_GAP(IRQ_GAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .node_id_zero_i(node_id_zero_i),
  .status_o(status_o), .mask_o(mask_o), .chain_o(chain_o), .irq_o(irq_o),
  .overflow_o(overflow_o), .tx_acc(tx_push_ok));

// File: tb/test_cmd_irq_unit.sv
module test_cmd_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, tx_done, tx_ack, rx_done, rx_busy, token, nid0;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] status, mask;
  logic       chain, irq, ovf, tx_go, rx_go;
  logic [3:0] tx_page, rx_page;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_irq_unit i_cmd_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tx_done_i(tx_done), .tx_ack_i(tx_ack),
    .rx_done_i(rx_done), .rx_busy_i(rx_busy), .token_i(token),
    .node_id_zero_i(nid0), .status_o(status), .mask_o(mask),
    .chain_o(chain), .irq_o(irq), .overflow_o(ovf), .tx_go_o(tx_go),
    .tx_page_o(tx_page), .rx_go_o(rx_go), .rx_page_o(rx_page));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0; wr_en = 0; wr_sel = 0; wr_data = 0; tx_done = 0;
    tx_ack = 0; rx_done = 0; rx_busy = 0; token = 0; nid0 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_txd(logic ack);
    tx_done = 1; tx_ack = ack; @(negedge clk); tx_done = 0; tx_ack = 0;
  endtask
  task automatic pulse_rxd(); rx_done = 1; @(negedge clk); rx_done = 0; endtask
  task automatic pulse_tok(); token = 1; @(negedge clk); token = 0; endtask

  task automatic t_reset();
    hw_reset();
    check("R1 status after reset", status & 8'h9F, 8'h91);
    check("R1 irq after reset", {7'd0, irq}, 8'd0);
    check("R1 overflow after reset", {7'd0, ovf}, 8'd0);
    check("R3 chain off after reset", {7'd0, chain}, 8'd0);
  endtask

  task automatic t_legacy_tx();
    hw_reset();
    wr(2'd0, 8'h54);
    check("R5 TA/TMA cleared", {6'd0, status[1:0]}, 8'd0);
    check("R5 tx page", {4'd0, tx_page}, 8'h5);
    wr(2'd0, 8'h64);
    check("R6 legacy overflow", {7'd0, ovf}, 8'd1);
    check("R6 dropped command", {4'd0, tx_page}, 8'h5);
    pulse_txd(1'b1);
    check("R5 TA/TMA after done", {6'd0, status[1:0]}, 8'd3);
    wr(2'd0, 8'h24);
    check("R5 TMA cleared again", {6'd0, status[1:0]}, 8'd0);
  endtask

  task automatic t_chain_tx();
    hw_reset();
    wr(2'd2, 8'h40);
    check("R3 chain on", {7'd0, chain}, 8'd1);
    wr(2'd0, 8'h34);
    wr(2'd0, 8'h74);
    check("R4 two accepted", {7'd0, ovf}, 8'd0);
    check("R4 oldest first", {4'd0, tx_page}, 8'h3);
    wr(2'd0, 8'h94);
    check("R6 chain overflow", {7'd0, ovf}, 8'd1);
    pulse_txd(1'b0);
    check("R4 second page", {4'd0, tx_page}, 8'h7);
    check("R5 TA still low", {6'd0, status[1:0]}, 8'd0);
    pulse_txd(1'b1);
    check("R5 TA after queue empty", {6'd0, status[1:0]}, 8'd3);
    check("R6 sticky", {7'd0, ovf}, 8'd1);
  endtask

  task automatic t_por();
    hw_reset();
    wr(2'd0, 8'h01);
    check("R2 clear flags", {7'd0, status[4]}, 8'd0);
    nid0 = 1; @(negedge clk); nid0 = 0;
    check("R2 node id zero", {7'd0, status[4]}, 8'd1);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h25);
    wr(2'd0, 8'h07);
    check("R1 soft reset status", status & 8'h9F, 8'h91);
    check("R1 soft reset queue", {7'd0, rx_go}, 8'd0);
  endtask

  task automatic t_mask();
    hw_reset();
    wr(2'd1, 8'h80);
    @(negedge clk);
    check("R7 legacy RI irq", {7'd0, irq}, 8'd1);
    hw_reset();
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h80);
    @(negedge clk);
    check("R7 chain ignores RI", {7'd0, irq}, 8'd0);
    wr(2'd0, 8'h35);
    check("R11 RI cleared", {7'd0, status[7]}, 8'd0);
    pulse_rxd();
    check("R11 TRI set", {7'd0, status[2]}, 8'd1);
    @(negedge clk);
    check("R7 chain TRI irq", {7'd0, irq}, 8'd1);
    wr(2'd0, 8'h01);
    check("R11 TRI cleared", {7'd0, status[2]}, 8'd0);
  endtask

  task automatic t_gap();
    int k;
    hw_reset();
    wr(2'd1, 8'h01);
    @(negedge clk);
    check("R7 TA irq", {7'd0, irq}, 8'd1);
    wr(2'd0, 8'h14);
    pulse_txd(1'b0);
    k = 0;
    while (irq == 1'b0 && k < 60) begin
      k++;
      @(negedge clk);
    end
    check("R8 low gap cycles", 8'(k), 8'd26);
  endtask

  task automatic t_dis_rx();
    hw_reset();
    wr(2'd0, 8'h25);
    check("R9 rx page", {4'd0, rx_page}, 8'h2);
    wr(2'd0, 8'h03);
    check("R9 wait for token", {7'd0, status[7]}, 8'd0);
    pulse_tok();
    check("R9 RI at token", {7'd0, status[7]}, 8'd1);
    check("R9 rx dropped", {7'd0, rx_go}, 8'd0);
    wr(2'd0, 8'h45);
    rx_busy = 1;
    wr(2'd0, 8'h03);
    pulse_tok();
    check("R9 busy rx continues", {7'd0, status[7]}, 8'd0);
    rx_busy = 0;
    pulse_rxd();
    check("R9 rx completes", {7'd0, status[7]}, 8'd1);
  endtask

  task automatic t_dis_tx();
    hw_reset();
    wr(2'd0, 8'hA4);
    wr(2'd0, 8'h02);
    check("R10 still pending", {7'd0, tx_go}, 8'd1);
    pulse_tok();
    check("R10 tx dropped", {7'd0, tx_go}, 8'd0);
    check("R10 TA set", {7'd0, status[0]}, 8'd1);
  endtask

  initial begin
    t_reset();
    t_legacy_tx();
    t_chain_tx();
    t_por();
    t_mask();
    t_gap();
    t_dis_rx();
    t_dis_tx();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule